// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO with Instant Rewind

This block is a dual-clock FIFO that presents data in fall-through fashion. The word at the head of the queue is already on `rd_data` whenever `out_ready` is high, so a read only has to take it. Writes run on `wr_clk` and reads on `rd_clk`. Each side keeps its own binary pointer. Pointers cross between the clock domains as Gray codes through two-stage synchronizers. The write side produces `in_ready`, `half_full` and `almost_full`. The read side produces `out_ready` and `almost_empty`.

A rewind input sends the read side back to the first word written since master reset, while the write pointer keeps its value. The rewind only works if `rtz_sel_n` was held low while the master reset was active. The first stored word is then on the output right after the rewind edge, with no extra read cycle. The feature is meant for replaying a short packet. The user must not write more than `DEPTH` words between master reset and the last rewind. If more are written, the words to be replayed have been overwritten.

Top module: `fifo_rt_top`

## Requirements
- R1: While `mrst_n` is low and on the clock edges of that reset, the outputs are `out_ready`=0, `in_ready`=1, `almost_empty`=1, `half_full`=0 and `almost_full`=0.
- R2: The oldest stored word is on `rd_data` with `out_ready`=1 and no read request. A rising `rd_clk` edge with `rd_en`=1 and `out_ready`=1 consumes that word. Words leave in the order they were written. `out_ready` falls only after a consuming read.
- R3: `rd_en` has no effect while `out_ready` is 0. No word is skipped or lost.
- R4: The FIFO holds at most `DEPTH` words. A write (`wr_en`=1 on a rising `wr_clk` edge) made while `in_ready` is 0 is discarded.
- R5: `almost_empty` is 1 when the read side counts `AE_OFS` words or fewer, and 0 otherwise.
- R6: `half_full` is 1 when the write side counts more than `DEPTH/2` words.
- R7: `almost_full` is 1 when the write side counts at least `DEPTH-AF_OFS` words. `in_ready` is 0 when that count equals `DEPTH`.
- R8: A rewind is accepted when `rewind`=1 on a rising `rd_clk` edge, zero-latency mode is selected, and at least two words have been written since reset. After an accepted rewind, the words are given out again in their original order, starting with the first word written after reset, followed by any words written later. The write side is not disturbed. `almost_empty` is recomputed from the restored count.
- R9: If a rewind is accepted while the FIFO is empty, `out_ready` is 1 right after that same `rd_clk` edge, and `rd_data` holds the first word written since reset.
- R10: A rewind is ignored when fewer than two words have been written since reset.
- R11: A rewind is ignored when `rtz_sel_n` was high during master reset.
- R12: A rewind on the same edge as a read takes priority. The read consumes nothing, and the output goes back to the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, sampled synchronously in both domains |
| rtz_sel_n | input | 1 | Rewind mode select, sampled during reset; low enables zero-latency rewind |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read request (takes the presented word) |
| rewind | input | 1 | Rewind request, read domain |
| rd_data | output | WIDTH | Head-of-queue word |
| out_ready | output | 1 | `rd_data` holds a valid word |
| in_ready | output | 1 | A write will be accepted |
| almost_empty | output | 1 | Read-side count at or below `AE_OFS` |
| half_full | output | 1 | Write-side count above `DEPTH/2` |
| almost_full | output | 1 | Write-side count at or above `DEPTH-AF_OFS` |

## Verification
The FIFO is first run with a short burst that is drained completely, to show fall-through presentation and ordering. A read request is then held while the FIFO is empty, to show that stalled reads consume nothing. A long overfilling burst checks each flag threshold one word before and one word after it flips, and shows that writes past capacity are discarded. Rewind is tried in four cases: from an empty FIFO, in the middle of a drain together with a read on the same edge, after a single write, and with the mode deselected. These cases separate a true replay from a pointer that never moved. They also show whether the two-word rule and the mode select are honoured.

// File: rtl/fifo_rt_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the fall-through FIFO with rewind.
// Assumes: nothing beyond standard SystemVerilog.
package fifo_rt_pkg;

    // Rewind behaviour latched at master reset
    typedef enum logic {
        RT_OFF      = 1'b0,
        RT_ZERO_LAT = 1'b1
    } rt_mode_e;

    // Number of synchronizer stages used on pointer crossings
    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/fifo_rt_sync.sv
`timescale 1ns/1ps
// Module: fifo_rt_sync
// Carries a Gray-coded pointer into another clock domain through a flop chain.
// Assumes: the input changes by at most one bit per source clock, except on rewind.
module fifo_rt_sync #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    import fifo_rt_pkg::*;

    logic [W-1:0] stage_q [SYNC_STAGES];

    // Shift the pointer through the synchronizer stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(SYNC_STAGES); i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < int'(SYNC_STAGES); i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[SYNC_STAGES-1];

endmodule

// File: rtl/fifo_rt_mem.sv
`timescale 1ns/1ps
// Module: fifo_rt_mem
// Storage array with a clocked write port and an asynchronous read port.
// Assumes: the reader only addresses locations the writer finished earlier.
module fifo_rt_mem #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cell_q [DEPTH];

    // Store an accepted word
    always_ff @(posedge wclk) begin
        if (we) cell_q[waddr] <= wdata;
    end

    // Present the addressed word combinationally for fall-through output
    assign rdata = cell_q[raddr];

endmodule

// File: rtl/fifo_rt_wside.sv
`timescale 1ns/1ps
// Module: fifo_rt_wside
// Write-domain control: pointer, acceptance and the fill-level flags.
// Assumes: rgray_sync is the read pointer already synchronized into wclk.
module fifo_rt_wside #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned AF_OFS = 2,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray_sync,
    output logic [AW-1:0] waddr,
    output logic          wr_fire,
    output logic [PW-1:0] wgray,
    output logic          in_ready,
    output logic          half_full,
    output logic          almost_full
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
    localparam logic [PW-1:0] AF_P    = PW'(DEPTH - AF_OFS);

    logic [PW-1:0] wptr_bin;
    logic [PW-1:0] wptr_next;
    logic [PW-1:0] rbin;
    logic [PW-1:0] lvl_next;

    // Decode the synchronized Gray read pointer
    always_comb begin
        for (int i = 0; i < int'(PW); i++) rbin[i] = ^(rgray_sync >> i);
    end

    assign wr_fire   = wr_en && in_ready;
    assign wptr_next = wptr_bin + PW'(wr_fire);
    assign lvl_next  = wptr_next - rbin;
    assign waddr     = wptr_bin[AW-1:0];

    // Advance the pointer and register the write-side flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_bin    <= '0;
            wgray       <= '0;
            in_ready    <= 1'b1;
            half_full   <= 1'b0;
            almost_full <= 1'b0;
        end else begin
            wptr_bin    <= wptr_next;
            wgray       <= wptr_next ^ (wptr_next >> 1);
            in_ready    <= lvl_next < DEPTH_P;
            half_full   <= lvl_next > HALF_P;
            almost_full <= lvl_next >= AF_P;
        end
    end

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_ready) |=> $stable(wptr_bin));

    // R7
    full_implies_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> almost_full);

    // R6
    full_implies_hf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> half_full);

endmodule

// File: rtl/fifo_rt_rside.sv
`timescale 1ns/1ps
// Module: fifo_rt_rside
// Read-domain control: fall-through pointer, output-ready, almost-empty and rewind.
// Assumes: wgray_sync is the write pointer synchronized into rclk; writes since
// reset do not exceed the depth when a rewind is used.
module fifo_rt_rside #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned AE_OFS = 2,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rtz_sel_n,
    input  logic          rd_en,
    input  logic          rewind,
    input  logic [PW-1:0] wgray_sync,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic          out_ready,
    output logic          almost_empty
);
    import fifo_rt_pkg::*;

    localparam logic [PW-1:0] AE_P  = PW'(AE_OFS);
    localparam logic [PW-1:0] TWO_P = PW'(2);

    rt_mode_e      mode_q;
    logic          two_seen;
    logic          rt_go;
    logic          rd_fire;
    logic [PW-1:0] rptr_bin;
    logic [PW-1:0] rptr_next;
    logic [PW-1:0] wbin;
    logic [PW-1:0] lvl_next;

    // Decode the synchronized Gray write pointer
    always_comb begin
        for (int i = 0; i < int'(PW); i++) wbin[i] = ^(wgray_sync >> i);
    end

    // Latch the rewind mode while master reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= rtz_sel_n ? RT_OFF : RT_ZERO_LAT;
    end

    // Remember that two or more words have been written since reset
    always_ff @(posedge clk) begin
        if (!rst_n)              two_seen <= 1'b0;
        else if (wbin >= TWO_P)  two_seen <= 1'b1;
    end

    assign rt_go     = rewind && (mode_q == RT_ZERO_LAT) && two_seen;
    assign rd_fire   = rd_en && out_ready && !rt_go;
    assign rptr_next = rt_go ? '0 : rptr_bin + PW'(rd_fire);
    assign lvl_next  = wbin - rptr_next;
    assign raddr     = rptr_bin[AW-1:0];

    // Move the read pointer and register the read-side flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_bin     <= '0;
            rgray        <= '0;
            out_ready    <= 1'b0;
            almost_empty <= 1'b1;
        end else begin
            rptr_bin     <= rptr_next;
            rgray        <= rptr_next ^ (rptr_next >> 1);
            out_ready    <= lvl_next != '0;
            almost_empty <= lvl_next <= AE_P;
        end
    end

    // R8
    rewind_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_go |=> (rptr_bin == '0 && out_ready));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_ready && !rt_go) |=> $stable(rptr_bin));

    // R2
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_ready) |-> $past(rd_en));

    // R11
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == RT_OFF && !(rd_en && out_ready)) |=> $stable(rptr_bin));

endmodule

// File: rtl/fifo_rt_top.sv
`timescale 1ns/1ps
// Module: fifo_rt_top
// Dual-clock fall-through FIFO with a zero-latency rewind to the first word
// written after master reset.
// Assumes: DEPTH is a power of two; mrst_n is held for several cycles of both clocks.
module fifo_rt_top #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned AE_OFS = 2,
    parameter int unsigned AF_OFS = 2,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PW    = AW + 1
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             mrst_n,
    input  logic             rtz_sel_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rewind,
    output logic [WIDTH-1:0] rd_data,
    output logic             out_ready,
    output logic             in_ready,
    output logic             almost_empty,
    output logic             half_full,
    output logic             almost_full
);
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic          wr_fire;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wgray_at_r;
    logic [PW-1:0] rgray_at_w;

    fifo_rt_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) mem_i (
        .wclk (wr_clk),
        .we   (wr_fire),
        .waddr(waddr),
        .wdata(wr_data),
        .raddr(raddr),
        .rdata(rd_data)
    );

    fifo_rt_sync #(.W(PW)) w2r_i (
        .clk  (rd_clk),
        .rst_n(mrst_n),
        .d    (wgray),
        .q    (wgray_at_r)
    );

    fifo_rt_sync #(.W(PW)) r2w_i (
        .clk  (wr_clk),
        .rst_n(mrst_n),
        .d    (rgray),
        .q    (rgray_at_w)
    );

    fifo_rt_wside #(.DEPTH(DEPTH), .AF_OFS(AF_OFS)) wside_i (
        .clk        (wr_clk),
        .rst_n      (mrst_n),
        .wr_en      (wr_en),
        .rgray_sync (rgray_at_w),
        .waddr      (waddr),
        .wr_fire    (wr_fire),
        .wgray      (wgray),
        .in_ready   (in_ready),
        .half_full  (half_full),
        .almost_full(almost_full)
    );

    fifo_rt_rside #(.DEPTH(DEPTH), .AE_OFS(AE_OFS)) rside_i (
        .clk         (rd_clk),
        .rst_n       (mrst_n),
        .rtz_sel_n   (rtz_sel_n),
        .rd_en       (rd_en),
        .rewind      (rewind),
        .wgray_sync  (wgray_at_r),
        .raddr       (raddr),
        .rgray       (rgray),
        .out_ready   (out_ready),
        .almost_empty(almost_empty)
    );

    // R1
    reset_state_chk: assert property (@(posedge rd_clk)
        $past(!mrst_n) && !mrst_n |-> (!out_ready && almost_empty));

endmodule

// File: tb/fifo_rt_top_tb_top.sv
`timescale 1ns/1ps
module fifo_rt_top_tb_top;
    localparam int WIDTH  = 16;
    localparam int DEPTH  = 16;
    localparam int AE_OFS = 2;
    localparam int AF_OFS = 2;

    logic             wr_clk = 1'b0;
    logic             rd_clk = 1'b0;
    logic             mrst_n = 1'b0;
    logic             rtz_sel_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_en = 1'b0;
    logic             rewind = 1'b0;
    logic [WIDTH-1:0] rd_data;
    logic             out_ready, in_ready, almost_empty, half_full, almost_full;

    logic [WIDTH-1:0] exp_q[$];
    logic [WIDTH-1:0] hist_q[$];
    int n_run = 0;
    int n_fail = 0;
    int pops = 0;
    bit done = 1'b0;

    fifo_rt_top #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .rtz_sel_n(rtz_sel_n),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rewind(rewind),
        .rd_data(rd_data), .out_ready(out_ready), .in_ready(in_ready),
        .almost_empty(almost_empty), .half_full(half_full), .almost_full(almost_full)
    );

    always #10 wr_clk = ~wr_clk;
    initial begin
        #5;
        forever #10 rd_clk = ~rd_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Monitor: compare each consumed word against the scoreboard (R2 ordering)
    initial forever begin
        @(posedge rd_clk);
        #18;
        if (mrst_n && rd_en && out_ready && !rewind) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected word", int'(rd_data), -1);
            end else begin
                chk(rd_data == exp_q[0], "R2 order", int'(rd_data), int'(exp_q[0]));
                exp_q.delete(0);
            end
            pops++;
        end
    end

    task automatic do_reset(input logic mode_n);
        @(negedge wr_clk);
        mrst_n = 1'b0; rtz_sel_n = mode_n;
        wr_en = 1'b0; rd_en = 1'b0; rewind = 1'b0;
        repeat (5) @(negedge rd_clk);
        @(negedge wr_clk);
        mrst_n = 1'b1;
        exp_q.delete();
        hist_q.delete();
        repeat (4) @(negedge rd_clk);
    endtask

    task automatic push(input logic [WIDTH-1:0] d, input bit accept);
        @(negedge wr_clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
        if (accept) begin
            exp_q.push_back(d);
            hist_q.push_back(d);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic read_n(input int n);
        int target;
        target = pops + n;
        @(negedge rd_clk);
        rd_en = 1'b1;
        while (pops < target) @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic do_rewind(input bit accept, input bit with_rd);
        @(negedge rd_clk);
        rewind = 1'b1; rd_en = with_rd;
        @(posedge rd_clk);
        #2;
        rewind = 1'b0; rd_en = 1'b0;
        if (accept) exp_q = hist_q;
    endtask

    initial begin
        // ---- Phase A: fall-through, stall, rewind (zero-latency mode)
        do_reset(1'b0);
        chk(out_ready == 1'b0, "R1 out_ready", int'(out_ready), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(almost_empty == 1'b1, "R1 almost_empty", int'(almost_empty), 1);
        chk(half_full == 1'b0, "R1 half_full", int'(half_full), 0);
        chk(almost_full == 1'b0, "R1 almost_full", int'(almost_full), 0);

        for (int i = 0; i < 5; i++) push(WIDTH'(16'h100 + i), 1'b1);
        settle();
        chk(out_ready == 1'b1, "R2 ready without read", int'(out_ready), 1);
        chk(rd_data == 16'h100, "R2 head word", int'(rd_data), 'h100);
        chk(almost_empty == 1'b0, "R5 five words", int'(almost_empty), 0);
        read_n(3);
        settle();
        chk(almost_empty == 1'b1, "R5 two words", int'(almost_empty), 1);
        read_n(2);
        settle();
        chk(out_ready == 1'b0, "R2 drained", int'(out_ready), 0);

        // R3: read request while empty
        @(negedge rd_clk);
        rd_en = 1'b1;
        repeat (4) @(negedge rd_clk);
        rd_en = 1'b0;
        push(16'h105, 1'b1);
        settle();
        chk(out_ready == 1'b1, "R3 ready after stall", int'(out_ready), 1);
        chk(rd_data == 16'h105, "R3 no word lost", int'(rd_data), 'h105);
        read_n(1);
        settle();

        // R9: rewind from empty
        do_rewind(1'b1, 1'b0);
        chk(out_ready == 1'b1, "R9 ready on rewind edge", int'(out_ready), 1);
        chk(rd_data == 16'h100, "R9 first word", int'(rd_data), 'h100);
        read_n(3);

        // R12: rewind together with a read
        do_rewind(1'b1, 1'b1);
        chk(rd_data == 16'h100, "R12 rewind wins", int'(rd_data), 'h100);
        settle();
        chk(almost_empty == 1'b0, "R8 flag recomputed", int'(almost_empty), 0);
        push(16'h106, 1'b1);
        read_n(7);
        settle();
        chk(out_ready == 1'b0, "R8 replay complete", int'(out_ready), 0);
        chk(exp_q.size() == 0, "R8 scoreboard empty", exp_q.size(), 0);

        // ---- Phase B: thresholds and overfill
        do_reset(1'b0);
        for (int i = 0; i < 20; i++) begin
            push(WIDTH'(16'h200 + i), i < DEPTH);
            if (i == 7)  chk(half_full == 1'b0, "R6 at half", int'(half_full), 0);
            if (i == 8)  chk(half_full == 1'b1, "R6 above half", int'(half_full), 1);
            if (i == 12) chk(almost_full == 1'b0, "R7 below af", int'(almost_full), 0);
            if (i == 13) chk(almost_full == 1'b1, "R7 at af", int'(almost_full), 1);
            if (i == 14) chk(in_ready == 1'b1, "R4 room left", int'(in_ready), 1);
            if (i == 15) chk(in_ready == 1'b0, "R7 full", int'(in_ready), 0);
        end
        settle();
        read_n(DEPTH);
        settle();
        chk(out_ready == 1'b0, "R4 extra writes dropped", int'(out_ready), 0);
        chk(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);

        // ---- Phase C: rewind after a single write
        do_reset(1'b0);
        push(16'h300, 1'b1);
        settle();
        read_n(1);
        settle();
        do_rewind(1'b0, 1'b0);
        settle();
        chk(out_ready == 1'b0, "R10 rewind ignored", int'(out_ready), 0);

        // ---- Phase D: mode deselected at reset
        do_reset(1'b1);
        for (int i = 0; i < 3; i++) push(WIDTH'(16'h400 + i), 1'b1);
        settle();
        read_n(3);
        settle();
        do_rewind(1'b0, 1'b0);
        settle();
        chk(out_ready == 1'b0, "R11 rewind ignored", int'(out_ready), 0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge wr_clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule